// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by reading a two-level page table from memory and writing the result into a translation buffer slot. A requester offers the virtual page number that missed, the slot index to fill, the current address-space context and an ordering tag. The block also samples the table root (the context base) in the same cycle. It then issues at most two word reads over a valid/ready request channel with a separate response strobe. It finishes with a one-cycle write of tag, context and entry data to the buffer, and pulses a done flag so a stalled pipeline can continue.

Only one walk is in progress at a time, and new requests are refused while the block is busy. A walk whose first-level entry is unmapped does not read the second level. It still writes a valid-tagged entry with zero data, so later lookups of that page fault from the buffer instead of walking again. A second-level entry is written as read, mapped or not, and the buffer reports the fault on lookup.

Top module: `ptw_top`

## Requirements
- R1: After reset `startReady` is 1 and `memReqValid`, `tlbWrEn` and `walkDone` are 0. With no start request they stay that way.
- R2: The first read address is the sampled context base plus (VA >> 20) with bits 1:0 cleared, i.e. base + {VA[31:22], 2'b00}. The sum wraps modulo 2^32.
- R3: The second read address is (first-level entry with bits 1:0 cleared) OR ((VA >> 10) AND 0xFFC), i.e. VA[21:12] placed at bits 11:2.
- R4: Bit 0 of a table entry is its mapping-valid bit. If it is 0 in the first-level entry, no second read is issued. The next cycle writes tag, context and index with data 0.
- R5: After the second-level response, the next cycle writes data equal to that response. The tag is the page address with bit 0 set, i.e. {VA[31:12], 12'h001}. Context and index are the sampled values.
- R6: A second-level entry whose bit 0 is 0 is still written unchanged as the entry data.
- R7: `tlbWrEn` and `walkDone` are high together for exactly one cycle per walk. The block is back in idle (`startReady` = 1) the cycle after.
- R8: A start is accepted when `startValid` and `startReady` are both 1. `startReady` stays 0 from the cycle after acceptance until the cycle after the write, so a start offered while busy is not taken.
- R9: A read request holds `memReqValid`, `memReqAddr` and `memReqOrd` steady until `memReqReady` is seen. `memReqOrd` carries the ordering tag sampled at acceptance.
- R10: Changes to the page number, index, context, ordering tag and context base after acceptance do not alter any address or field the walk produces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startValid | input | 1 | Miss presented for walking |
| startReady | output | 1 | Walker idle and able to accept |
| missVpn | input | 20 | Virtual page number (VA[31:12]) that missed |
| missIdx | input | 6 | Buffer slot to fill |
| missCtx | input | 8 | Current context |
| missOrd | input | 16 | Requester ordering tag |
| ctxBase | input | 32 | First-level table base for the context |
| memReqValid | output | 1 | Word read request |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 32 | Word read address |
| memReqOrd | output | 16 | Ordering tag carried with the read |
| memRspValid | input | 1 | Read data returned |
| memRspData | input | 32 | Returned table entry |
| tlbWrEn | output | 1 | Buffer write strobe |
| tlbWrIdx | output | 6 | Slot being written |
| tlbWrTag | output | 32 | Page address with valid bit 0 set |
| tlbWrCtx | output | 8 | Context of the entry |
| tlbWrData | output | 32 | Entry data (0 on a first-level fault) |
| walkDone | output | 1 | Walk finished, requester may resume |

## Verification
The bench targets an unmapped first-level entry, including one with bit 1 set but bit 0 clear. A walker that tested the wrong bit, or issued the second read anyway, would fetch garbage and write a nonzero entry. A first-level entry with its low bits set checks the masking, since a walker that kept them would read from a misaligned address. A base near the top of the address space checks wrap-around in the first-level sum. Unmapped second-level data must pass through unchanged, so a walker that zeroed it would lose the fault attribute. Inputs are scrambled and a second start is offered mid-walk: a walker that used live inputs would write the wrong tag or context, and one that accepted the extra start would corrupt the walk in flight.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L0_REQ,
    ST_L0_WAIT,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_WRITE
  } walk_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;   // sample request fields
    logic capEntry;   // store returned entry
    logic clrEntry;   // zero entry (first-level fault)
    logic reqValid;   // drive a memory read
    logic selL1;      // second-level address select
    logic wrEn;       // buffer write
  } ptw_strobe_t;

endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        rspMapped,
  output logic        startReady,
  output logic        walkDone,
  output ptw_strobe_t strb
);

  walk_state_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:    if (startValid)  stateNxt = ST_L0_REQ;
      ST_L0_REQ:  if (memReqReady) stateNxt = ST_L0_WAIT;
      ST_L0_WAIT: if (memRspValid) stateNxt = rspMapped ? ST_L1_REQ : ST_WRITE;
      ST_L1_REQ:  if (memReqReady) stateNxt = ST_L1_WAIT;
      ST_L1_WAIT: if (memRspValid) stateNxt = ST_WRITE;
      ST_WRITE:   stateNxt = ST_IDLE;
      default:    stateNxt = ST_IDLE;
    endcase
  end

  always_comb begin
    strb          = '0;
    strb.latchReq = (state == ST_IDLE) && startValid;
    strb.reqValid = (state == ST_L0_REQ) || (state == ST_L1_REQ);
    strb.selL1    = (state == ST_L1_REQ);
    strb.capEntry = memRspValid &&
                    (((state == ST_L0_WAIT) && rspMapped) || (state == ST_L1_WAIT));
    strb.clrEntry = memRspValid && (state == ST_L0_WAIT) && !rspMapped;
    strb.wrEn     = (state == ST_WRITE);
  end

  assign startReady = (state == ST_IDLE);
  assign walkDone   = (state == ST_WRITE);

endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int AW       = 32,
  parameter int IDX_W    = 6,
  parameter int CTX_W    = 8,
  parameter int ORD_W    = 16,
  parameter int PAGE_OFS = 12,
  parameter int LVL_BITS = 10,
  parameter int MV_BIT   = 0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ptw_strobe_t              strb,
  input  logic [VA_W-PAGE_OFS-1:0] missVpn,
  input  logic [IDX_W-1:0]         missIdx,
  input  logic [CTX_W-1:0]         missCtx,
  input  logic [ORD_W-1:0]         missOrd,
  input  logic [AW-1:0]            ctxBase,
  input  logic [AW-1:0]            memRspData,
  output logic                     rspMapped,
  output logic [AW-1:0]            memReqAddr,
  output logic [ORD_W-1:0]         memReqOrd,
  output logic [IDX_W-1:0]         tlbWrIdx,
  output logic [VA_W-1:0]          tlbWrTag,
  output logic [CTX_W-1:0]         tlbWrCtx,
  output logic [AW-1:0]            tlbWrData
);

  localparam int VPN_W = VA_W - PAGE_OFS;
  localparam int L0_LO = PAGE_OFS + LVL_BITS;   // VA bit where L0 index starts
  localparam int L0_W  = VA_W - L0_LO;          // L0 index width
  localparam int L1_W  = LVL_BITS;              // L1 index width

  logic [VPN_W-1:0] vpnQ;
  logic [IDX_W-1:0] idxQ;
  logic [CTX_W-1:0] ctxQ;
  logic [ORD_W-1:0] ordQ;
  logic [AW-1:0]    baseQ;
  logic [AW-1:0]    entryQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vpnQ  <= '0;
      idxQ  <= '0;
      ctxQ  <= '0;
      ordQ  <= '0;
      baseQ <= '0;
    end else if (strb.latchReq) begin
      vpnQ  <= missVpn;
      idxQ  <= missIdx;
      ctxQ  <= missCtx;
      ordQ  <= missOrd;
      baseQ <= ctxBase;
    end
  end

  // one register carries the L0 entry, then the L1 entry (or zero)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              entryQ <= '0;
    else if (strb.clrEntry) entryQ <= '0;
    else if (strb.capEntry) entryQ <= memRspData;
  end

  // word offsets of the two table indices
  logic [AW-1:0] l0Ofs, l1Ofs, l0Addr, l1Addr, ptrBase;

  always_comb begin
    l0Ofs = '0;
    l0Ofs[L0_W+1:0] = {vpnQ[VPN_W-1 -: L0_W], 2'b00};
    l1Ofs = '0;
    l1Ofs[L1_W+1:0] = {vpnQ[L1_W-1:0], 2'b00};
  end

  assign ptrBase    = {entryQ[AW-1:2], 2'b00};
  assign l0Addr     = baseQ + l0Ofs;
  assign l1Addr     = ptrBase | l1Ofs;
  assign memReqAddr = strb.selL1 ? l1Addr : l0Addr;
  assign memReqOrd  = ordQ;
  assign rspMapped  = memRspData[MV_BIT];

  assign tlbWrIdx  = idxQ;
  assign tlbWrCtx  = ctxQ;
  assign tlbWrData = entryQ;
  assign tlbWrTag  = {vpnQ, {(PAGE_OFS-1){1'b0}}, 1'b1};

endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int AW       = 32,
  parameter int IDX_W    = 6,
  parameter int CTX_W    = 8,
  parameter int ORD_W    = 16,
  parameter int PAGE_OFS = 12,
  parameter int LVL_BITS = 10,
  parameter int MV_BIT   = 0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startValid,
  output logic                     startReady,
  input  logic [VA_W-PAGE_OFS-1:0] missVpn,
  input  logic [IDX_W-1:0]         missIdx,
  input  logic [CTX_W-1:0]         missCtx,
  input  logic [ORD_W-1:0]         missOrd,
  input  logic [AW-1:0]            ctxBase,
  output logic                     memReqValid,
  input  logic                     memReqReady,
  output logic [AW-1:0]            memReqAddr,
  output logic [ORD_W-1:0]         memReqOrd,
  input  logic                     memRspValid,
  input  logic [AW-1:0]            memRspData,
  output logic                     tlbWrEn,
  output logic [IDX_W-1:0]         tlbWrIdx,
  output logic [VA_W-1:0]          tlbWrTag,
  output logic [CTX_W-1:0]         tlbWrCtx,
  output logic [AW-1:0]            tlbWrData,
  output logic                     walkDone
);

  ptw_strobe_t strb;
  logic        rspMapped;

  ptw_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .rspMapped  (rspMapped),
    .startReady (startReady),
    .walkDone   (walkDone),
    .strb       (strb)
  );

  ptw_datapath #(
    .VA_W(VA_W), .AW(AW), .IDX_W(IDX_W), .CTX_W(CTX_W), .ORD_W(ORD_W),
    .PAGE_OFS(PAGE_OFS), .LVL_BITS(LVL_BITS), .MV_BIT(MV_BIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .missVpn   (missVpn),
    .missIdx   (missIdx),
    .missCtx   (missCtx),
    .missOrd   (missOrd),
    .ctxBase   (ctxBase),
    .memRspData(memRspData),
    .rspMapped (rspMapped),
    .memReqAddr(memReqAddr),
    .memReqOrd (memReqOrd),
    .tlbWrIdx  (tlbWrIdx),
    .tlbWrTag  (tlbWrTag),
    .tlbWrCtx  (tlbWrCtx),
    .tlbWrData (tlbWrData)
  );

  assign memReqValid = strb.reqValid;
  assign tlbWrEn     = strb.wrEn;

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int AW    = 32,
  parameter int ORD_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             startValid,
  input logic             startReady,
  input logic             memReqValid,
  input logic             memReqReady,
  input logic [AW-1:0]    memReqAddr,
  input logic [ORD_W-1:0] memReqOrd,
  input logic             tlbWrEn
);

  a_r8_accept_starts_walk: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && startReady) |=> (!startReady && memReqValid));

  a_r8_no_accept_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !startReady);

  a_r9_request_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=>
      (memReqValid && $stable(memReqAddr) && $stable(memReqOrd)));

  a_r7_single_write: assert property (@(posedge clk) disable iff (!rstN)
    tlbWrEn |=> (!tlbWrEn && startReady));

  a_r10_order_tag_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!startReady && !$past(startReady)) |-> $stable(memReqOrd));

endmodule

bind ptw_top ptw_checker #(.AW(AW), .ORD_W(ORD_W)) u_ptw_checker (
  .clk        (clk),
  .rstN       (rstN),
  .startValid (startValid),
  .startReady (startReady),
  .memReqValid(memReqValid),
  .memReqReady(memReqReady),
  .memReqAddr (memReqAddr),
  .memReqOrd  (memReqOrd),
  .tlbWrEn    (tlbWrEn)
);

// File: tb/tb_ptw_top.sv
module tb_ptw_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic        startReady;
  logic [19:0] missVpn = '0;
  logic [5:0]  missIdx = '0;
  logic [7:0]  missCtx = '0;
  logic [15:0] missOrd = '0;
  logic [31:0] ctxBase = '0;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [31:0] memReqAddr;
  logic [15:0] memReqOrd;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        tlbWrEn;
  logic [5:0]  tlbWrIdx;
  logic [31:0] tlbWrTag;
  logic [7:0]  tlbWrCtx;
  logic [31:0] tlbWrData;
  logic        walkDone;

  always #2 clk = ~clk;

  ptw_top dut (.*);

  int  nRun = 0;
  int  nFail = 0;
  bit  finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] expL0(input logic [31:0] va, input logic [31:0] base);
    return base + ((va >> 20) & ~32'h3);
  endfunction
  function automatic logic [31:0] expL1(input logic [31:0] va, input logic [31:0] e0);
    return (e0 & ~32'h3) | ((va >> 10) & 32'hFFC);
  endfunction
  function automatic logic [31:0] expTag(input logic [31:0] va);
    return (va & ~32'hFFF) | 32'h1;
  endfunction

  typedef struct packed {
    logic [31:0] va;
    logic [5:0]  idx;
    logic [7:0]  ctx;
    logic [15:0] ord;
    logic [31:0] base;
    logic [31:0] e0;
    logic [31:0] e1;
    logic [2:0]  reqLat;
    logic [2:0]  rspLat;
    logic        expFault;   // first-level entry unmapped
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{32'h1234_5678, 6'd3,  8'h11, 16'h0101, 32'h0001_0000, 32'h0002_0001, 32'h000A_B00F, 3'd0, 3'd0, 1'b0},
    '{32'hFFFF_F000, 6'd63, 8'hFF, 16'hFFFE, 32'h8000_0000, 32'hFFFF_F003, 32'h0000_0001, 3'd2, 3'd3, 1'b0},
    '{32'h0000_0ABC, 6'd0,  8'h00, 16'h0000, 32'h0000_0000, 32'h0000_0000, 32'h1111_1111, 3'd1, 3'd1, 1'b1},
    '{32'hABCD_EFFF, 6'd21, 8'h5A, 16'h1234, 32'h0040_0000, 32'h0000_4002, 32'h2222_2223, 3'd0, 3'd2, 1'b1},
    '{32'h0040_1000, 6'd40, 8'hA5, 16'h4321, 32'h0010_0000, 32'h0030_0001, 32'h0000_5000, 3'd0, 3'd2, 1'b0},
    '{32'h7FC0_3FFC, 6'd9,  8'h3C, 16'h8000, 32'hFFFF_FFF0, 32'h0000_0001, 32'hDEAD_BEEF, 3'd1, 3'd0, 1'b0}
  };

  // handshake one read; caller sits at a negedge with memReqValid high
  task automatic serveRead(input logic [31:0] addr, input logic [15:0] ord,
                           input logic [2:0] reqLat, input logic [2:0] rspLat,
                           input logic [31:0] data, input string req);
    chk(memReqValid, req, {31'b0, memReqValid}, 32'h1);
    chk(memReqAddr == addr, req, memReqAddr, addr);
    chk(memReqOrd == ord, "R9", {16'b0, memReqOrd}, {16'b0, ord});
    for (int k = 0; k < int'(reqLat); k++) begin
      @(negedge clk);
      chk(memReqValid && memReqAddr == addr, "R9", memReqAddr, addr);
    end
    memReqReady = 1'b1;
    @(negedge clk);
    memReqReady = 1'b0;
    chk(!memReqValid, "R9", {31'b0, memReqValid}, 32'h0);
    for (int k = 0; k < int'(rspLat); k++) @(negedge clk);
    memRspValid = 1'b1;
    memRspData  = data;
    @(negedge clk);
    memRspValid = 1'b0;
    memRspData  = '0;
  endtask

  task automatic runVec(input vec_t v);
    logic [31:0] wantData;
    @(negedge clk);
    chk(startReady, "R8", {31'b0, startReady}, 32'h1);
    startValid = 1'b1;
    missVpn = v.va[31:12]; missIdx = v.idx; missCtx = v.ctx;
    missOrd = v.ord;       ctxBase = v.base;
    @(negedge clk);
    startValid = 1'b0;
    // R10: scramble all request inputs after acceptance
    missVpn = ~v.va[31:12]; missIdx = ~v.idx; missCtx = ~v.ctx;
    missOrd = ~v.ord;       ctxBase = ~v.base;
    chk(!startReady, "R8", {31'b0, startReady}, 32'h0);
    serveRead(expL0(v.va, v.base), v.ord, v.reqLat, v.rspLat, v.e0, "R2");
    if (v.expFault) begin
      wantData = 32'h0;
      chk(!memReqValid, "R4", {31'b0, memReqValid}, 32'h0);
      chk(tlbWrData == wantData, "R4", tlbWrData, wantData);
    end else begin
      // R8: a second start while busy must be refused
      chk(!startReady, "R8", {31'b0, startReady}, 32'h0);
      serveRead(expL1(v.va, v.e0), v.ord, v.reqLat, v.rspLat, v.e1, "R3");
      wantData = v.e1;
      chk(tlbWrData == wantData, v.e1[0] ? "R5" : "R6", tlbWrData, wantData);
    end
    chk(tlbWrEn && walkDone, "R7", {30'b0, tlbWrEn, walkDone}, 32'h3);
    chk(tlbWrTag == expTag(v.va), "R5", tlbWrTag, expTag(v.va));
    chk(tlbWrCtx == v.ctx, "R10", {24'b0, tlbWrCtx}, {24'b0, v.ctx});
    chk(tlbWrIdx == v.idx, "R10", {26'b0, tlbWrIdx}, {26'b0, v.idx});
    @(negedge clk);
    chk(!tlbWrEn && !walkDone, "R7", {30'b0, tlbWrEn, walkDone}, 32'h0);
    chk(startReady && !memReqValid, "R7", {30'b0, startReady, memReqValid}, 32'h2);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(startReady, "R1", {31'b0, startReady}, 32'h1);
    chk(!memReqValid && !tlbWrEn && !walkDone, "R1",
        {29'b0, memReqValid, tlbWrEn, walkDone}, 32'h0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk(startReady && !memReqValid && !tlbWrEn, "R1",
        {29'b0, startReady, memReqValid, tlbWrEn}, 32'h4);

    for (int i = 0; i < NVEC; i++) runVec(VECS[i]);

    // R8: start offered during the wait phase is not taken
    @(negedge clk);
    startValid = 1'b1; missVpn = 20'h00123; ctxBase = 32'h0000_1000;
    missOrd = 16'h00AA; missIdx = 6'd7; missCtx = 8'h77;
    @(negedge clk);
    startValid = 1'b0;
    memReqReady = 1'b1;
    @(negedge clk);
    memReqReady = 1'b0;
    startValid = 1'b1; missVpn = 20'hFFFFF;
    @(negedge clk);
    chk(!startReady && !memReqValid, "R8", {30'b0, startReady, memReqValid}, 32'h0);
    startValid = 1'b0;
    memRspValid = 1'b1; memRspData = 32'h0;
    @(negedge clk);
    memRspValid = 1'b0;
    chk(tlbWrEn && tlbWrTag == 32'h0012_3001, "R8", tlbWrTag, 32'h0012_3001);
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!memReqValid && !tlbWrEn, "R1", {30'b0, memReqValid, tlbWrEn}, 32'h0);

    // R1: reset in the middle of a walk returns to idle
    startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    chk(memReqValid, "R2", {31'b0, memReqValid}, 32'h1);
    rstN = 1'b0;
    @(negedge clk);
    chk(startReady && !memReqValid && !walkDone, "R1",
        {29'b0, startReady, memReqValid, walkDone}, 32'h4);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(startReady && !memReqValid, "R1", {30'b0, startReady, memReqValid}, 32'h2);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule